// File: doc/BRIEF.md
# Lockable Pin Crossbar with Shadow Check

This block routes signals between a set of peripheral outputs, a set of peripheral inputs and a set of physical I/O pins. Each pin owns a select register that names the single peripheral output driving it. Each peripheral input owns a select register that names the single pin it samples. Because every destination names exactly one source, one source can fan out to many destinations. Two sources can never meet on one destination, so output shorts and input contention cannot be configured.

The select registers are protected. They are written through a plain write-only register port and stay locked until a two-step key is written to the key address. That key opens a fixed-length window, after which the registers lock again. A write to a select register while locked changes nothing and raises a sticky error flag.

Every select register has a second, shadow copy that is written together with the live copy. The two copies are compared on every cycle. A difference on a pin's register turns that pin's output enable off. A difference on an input's register forces that input to 0. In both cases a fault flag is raised. The disabled destination and the fault flag stay in that state until reset. Control pins are plain levels sampled on the rising clock edge, and there is no back-pressure.

Top module: `pin_xbar`

## Requirements
- R1: After a synchronous reset (`rst` high on a rising edge), every select register is 0. All `pin_oe` and `pin_out` bits are 0, all `periph_in` bits are 0, and `unlocked`, `wr_err` and `fault` are 0.
- R2: A pin select value k in 1..NOUT drives the pin from `periph_out[k-1]` with `pin_oe` high. A value of 0 or above NOUT leaves the pin with `pin_oe` low and `pin_out` 0. Several pins may name the same output.
- R3: An input select value k in 1..NPINS makes `periph_in` equal `pin_in[k-1]`. A value of 0 or above NPINS makes it 0. Several inputs may name the same pin.
- R4: Address 0 is the key register. Address 1+p is the select of pin p. Address 1+NPINS+i is the select of peripheral input i. The low SELW bits of `wr_data` form the stored select value. Addresses above NPINS+NIN are ignored.
- R5: The window opens only when 0x55 and then 0xAA are written to address 0 with no other write between them; idle cycles between them are allowed. Any other key value, or a write to any other address, cancels the pending first step.
- R6: `unlocked` rises on the cycle after the 0xAA write and stays high for exactly 16 cycles. Select writes sampled on any of those 16 edges are stored; a later write is not.
- R7: A select write sampled while locked leaves the mapping unchanged and sets `wr_err`. `wr_err` stays high until reset.
- R8: If the live and shadow copies of a register differ, then one cycle later `fault` rises and the affected pin has `pin_oe` low, or the affected input reads 0. Both remain so until reset, even if the copies agree again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| periph_out | input | NOUT | Peripheral output functions |
| pin_in | input | NPINS | Levels read from the pins |
| pin_out | output | NPINS | Level driven on each pin |
| pin_oe | output | NPINS | Output enable of each pin |
| periph_in | output | NIN | Peripheral input functions |
| unlocked | output | 1 | Select write window open |
| wr_err | output | 1 | Sticky locked-write error |
| fault | output | 1 | Sticky shadow mismatch fault |

## Verification
Several properties are checked on every cycle:
- the mapping never changes while locked;
- the window opens only right after a second key write;
- the error and fault flags never drop;
- a mismatch always leads to a fault;
- a faulted pin never has its output enabled.

Only the bench scenarios can show the rest. These cover the exact 16-edge window boundary, a key sequence broken by stray writes, and the routing values for one-to-many and out-of-range selects. They also cover recovery after reset once a corrupted shadow copy has been injected.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_OPEN = 8'hAA;
endpackage

// File: rtl/pin_xbar_unlock.sv
module pin_xbar_unlock
  import pin_xbar_pkg::*;
#(
  parameter int AW  = 8,
  parameter int WIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked
);
  localparam int CW = $clog2(WIN + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic          key_hit;
  logic          open_req;

  assign key_hit  = wr_en && (wr_addr == '0);
  assign open_req = key_hit && armed && (wr_data == KEY_OPEN);

  // first key step is remembered until any other write arrives
  always_ff @(posedge clk) begin
    if (rst)        armed <= 1'b0;
    else if (wr_en) armed <= key_hit && (wr_data == KEY_ARM);
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (open_req)    cnt <= CW'(WIN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign unlocked = (cnt != '0);
endmodule

// File: rtl/pin_xbar_bank.sv
module pin_xbar_bank #(
  parameter int NREG = 12,
  parameter int SELW = 4,
  parameter int IW   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IW-1:0]             idx,
  input  logic [SELW-1:0]           d,
  output logic [NREG-1:0][SELW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (we && (idx == IW'(r))) q[r] <= d;
      end
    end
  end
endmodule

// File: rtl/pin_xbar_cfg.sv
module pin_xbar_cfg #(
  parameter int NPINS = 8,
  parameter int NIN   = 4,
  parameter int SELW  = 4,
  parameter int AW    = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [SELW-1:0]                   wr_sel,
  input  logic                              unlocked,
  output logic [NPINS+NIN-1:0][SELW-1:0]    cfg_q,
  output logic [NPINS-1:0]                  pin_bad,
  output logic [NIN-1:0]                    in_bad,
  output logic                              wr_err,
  output logic                              fault
);
  localparam int NREG = NPINS + NIN;
  localparam int IW   = $clog2(NREG);

  logic                      map_hit;
  logic                      map_we;
  logic [IW-1:0]             map_idx;
  logic [NREG-1:0][SELW-1:0] shadow_q;
  logic [NREG-1:0]           mism;

  assign map_hit = wr_en && (wr_addr != '0) && (wr_addr <= AW'(NREG));
  assign map_we  = map_hit && unlocked;
  assign map_idx = IW'(wr_addr - AW'(1));

  pin_xbar_bank #(.NREG(NREG), .SELW(SELW), .IW(IW)) u_live (
    .clk(clk), .rst(rst), .we(map_we), .idx(map_idx), .d(wr_sel), .q(cfg_q)
  );

  pin_xbar_bank #(.NREG(NREG), .SELW(SELW), .IW(IW)) u_shadow (
    .clk(clk), .rst(rst), .we(map_we), .idx(map_idx), .d(wr_sel), .q(shadow_q)
  );

  always_comb begin
    for (int r = 0; r < NREG; r++) mism[r] = (cfg_q[r] != shadow_q[r]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err  <= 1'b0;
      pin_bad <= '0;
      in_bad  <= '0;
    end else begin
      wr_err  <= wr_err | (map_hit && !unlocked);
      pin_bad <= pin_bad | mism[NPINS-1:0];
      in_bad  <= in_bad | mism[NREG-1:NPINS];
    end
  end

  assign fault = (|pin_bad) || (|in_bad);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);
  assert_mismatch_faults_R8: assert property (@(posedge clk) disable iff (rst)
    (|mism) |=> fault);
endmodule

// File: rtl/pin_xbar_route.sv
module pin_xbar_route #(
  parameter int NPINS = 8,
  parameter int NOUT  = 4,
  parameter int NIN   = 4,
  parameter int SELW  = 4
) (
  input  logic [NPINS+NIN-1:0][SELW-1:0] cfg_q,
  input  logic [NPINS-1:0]               pin_bad,
  input  logic [NIN-1:0]                 in_bad,
  input  logic [NOUT-1:0]                periph_out,
  input  logic [NPINS-1:0]               pin_in,
  output logic [NPINS-1:0]               pin_out,
  output logic [NPINS-1:0]               pin_oe,
  output logic [NIN-1:0]                 periph_in
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      pin_out[p] = 1'b0;
      pin_oe[p]  = 1'b0;
      for (int k = 0; k < NOUT; k++) begin
        if (!pin_bad[p] && (cfg_q[p] == SELW'(k + 1))) begin
          pin_out[p] = periph_out[k];
          pin_oe[p]  = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NIN; i++) begin : g_in
    always_comb begin
      periph_in[i] = 1'b0;
      for (int k = 0; k < NPINS; k++) begin
        if (!in_bad[i] && (cfg_q[NPINS+i] == SELW'(k + 1))) periph_in[i] = pin_in[k];
      end
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NOUT  = 4,
  parameter int NIN   = 4,
  parameter int AW    = 8,
  parameter int WIN   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NOUT-1:0]   periph_out,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NIN-1:0]    periph_in,
  output logic              unlocked,
  output logic              wr_err,
  output logic              fault
);
  localparam int NREG = NPINS + NIN;
  localparam int SELW = $clog2(((NPINS > NOUT) ? NPINS : NOUT) + 1);

  logic [NREG-1:0][SELW-1:0] cfg_q;
  logic [NPINS-1:0]          pin_bad;
  logic [NIN-1:0]            in_bad;

  pin_xbar_unlock #(.AW(AW), .WIN(WIN)) u_unlock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlocked(unlocked)
  );

  pin_xbar_cfg #(.NPINS(NPINS), .NIN(NIN), .SELW(SELW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_sel(wr_data[SELW-1:0]), .unlocked(unlocked), .cfg_q(cfg_q),
    .pin_bad(pin_bad), .in_bad(in_bad), .wr_err(wr_err), .fault(fault)
  );

  pin_xbar_route #(.NPINS(NPINS), .NOUT(NOUT), .NIN(NIN), .SELW(SELW)) u_route (
    .cfg_q(cfg_q), .pin_bad(pin_bad), .in_bad(in_bad), .periph_out(periph_out),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .periph_in(periph_in)
  );

  assert_locked_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(cfg_q));
  assert_open_after_key_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(wr_en && (wr_addr == '0) && (wr_data == KEY_OPEN)));

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    assert_bad_pin_off_R8: assert property (@(posedge clk) disable iff (rst)
      pin_bad[p] |-> !pin_oe[p]);
  end
endmodule

// File: tb/pin_xbar_test.sv
`timescale 1ns/1ps
module pin_xbar_test;
  localparam int NPINS = 8;
  localparam int NOUT  = 4;
  localparam int NIN   = 4;
  localparam int AW    = 8;
  localparam int WIN   = 16;
  localparam int NREG  = NPINS + NIN;
  localparam int SELW  = 4;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [NOUT-1:0] periph_out = '0;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic [NIN-1:0] periph_in;
  logic unlocked, wr_err, fault;

  pin_xbar #(.NPINS(NPINS), .NOUT(NOUT), .NIN(NIN), .AW(AW), .WIN(WIN)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .periph_out(periph_out), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .periph_in(periph_in), .unlocked(unlocked), .wr_err(wr_err), .fault(fault)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  int cyc = 0;

  // behavioural reference state
  int psel[NPINS];
  int isel[NIN];
  int win = 0;
  bit armed = 0;
  bit err_m = 0;
  bit pbad[NPINS];
  bit ibad[NIN];
  bit pmask[NPINS];
  bit imask[NIN];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit ul;
    int nwin;
    started = 1;
    if (rst) begin
      for (int p = 0; p < NPINS; p++) begin psel[p] = 0; pbad[p] = 0; end
      for (int i = 0; i < NIN; i++) begin isel[i] = 0; ibad[i] = 0; end
      win = 0; armed = 0; err_m = 0;
    end else begin
      ul = (win > 0);
      nwin = (win > 0) ? win - 1 : 0;
      if (wr_en) begin
        if (wr_addr == 0) begin
          if (armed && wr_data == 8'hAA) nwin = WIN;
          armed = (wr_data == 8'h55);
        end else begin
          armed = 0;
          if (int'(wr_addr) <= NREG) begin
            if (ul) begin
              if (int'(wr_addr) <= NPINS) psel[int'(wr_addr) - 1] = int'(wr_data) & 15;
              else isel[int'(wr_addr) - 1 - NPINS] = int'(wr_data) & 15;
            end else err_m = 1;
          end
        end
      end
      win = nwin;
      for (int p = 0; p < NPINS; p++) pbad[p] = pbad[p] | pmask[p];
      for (int i = 0; i < NIN; i++) ibad[i] = ibad[i] | imask[i];
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    logic [NPINS-1:0] eo, ev;
    logic [NIN-1:0] ei;
    if (started && !done) begin
      for (int p = 0; p < NPINS; p++) begin
        eo[p] = !pbad[p] && psel[p] >= 1 && psel[p] <= NOUT;
        ev[p] = eo[p] ? periph_out[psel[p] - 1] : 1'b0;
      end
      for (int i = 0; i < NIN; i++)
        ei[i] = (!ibad[i] && isel[i] >= 1 && isel[i] <= NPINS) ? pin_in[isel[i] - 1] : 1'b0;
      chk(pin_oe == eo, "R2", "pin_oe", int'(pin_oe), int'(eo));
      chk(pin_out == ev, "R2", "pin_out", int'(pin_out), int'(ev));
      chk(periph_in == ei, "R3", "periph_in", int'(periph_in), int'(ei));
      chk(unlocked == (win > 0), "R6", "unlocked", int'(unlocked), int'(win > 0));
      chk(wr_err == err_m, "R7", "wr_err", int'(wr_err), int'(err_m));
      chk(fault == (pbad.or() | ibad.or()), "R8", "fault", int'(fault),
          int'(pbad.or() | ibad.or()));
    end
  end

  always @(posedge clk) begin
    #1;
    periph_out = NOUT'($urandom);
    pin_in = NPINS'($urandom);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  logic [NREG*SELW-1:0] fv;

  initial begin
    for (int p = 0; p < NPINS; p++) pmask[p] = 0;
    for (int i = 0; i < NIN; i++) imask[i] = 0;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    // R1 reset state
    chk(pin_oe == 0 && pin_out == 0 && unlocked == 0 && wr_err == 0 && fault == 0,
        "R1", "reset state", int'({pin_oe, unlocked, wr_err, fault}), 0);
    chk(periph_in == 0, "R1", "inputs after reset", int'(periph_in), 0);

    // R7 locked write ignored, flag set
    wr(1, 2); idle(1);
    chk(wr_err == 1, "R7", "locked write error", int'(wr_err), 1);
    chk(pin_oe == 0, "R7", "locked write ignored", int'(pin_oe), 0);

    // R5 valid key opens window
    wr(0, 8'h55); wr(0, 8'hAA);
    chk(unlocked == 1, "R5", "key opens window", int'(unlocked), 1);
    // R4 address map and field bits; R2 one-to-many and out of range
    wr(1, 1); wr(2, 1); wr(3, 3); wr(4, 4); wr(5, 5); wr(6, 8'h12);
    wr(9, 1); wr(10, 3); wr(11, 3); wr(12, 9); wr(13, 1);
    idle(1);
    chk(pin_oe == 8'h2F, "R4", "pins enabled by map", int'(pin_oe), 8'h2F);
    idle(20);

    // R6 relocked after window
    chk(unlocked == 0, "R6", "relock", int'(unlocked), 0);
    wr(1, 0); idle(1);
    chk(pin_oe[0] == 1, "R7", "locked write kept pin0", int'(pin_oe[0]), 1);

    // R5 broken sequences
    wr(0, 8'h55); wr(5, 2); wr(0, 8'hAA);
    chk(unlocked == 0, "R5", "stray write cancels key", int'(unlocked), 0);
    wr(0, 8'h55); wr(0, 8'h12); wr(0, 8'hAA);
    chk(unlocked == 0, "R5", "wrong key cancels", int'(unlocked), 0);
    wr(0, 8'hAA);
    chk(unlocked == 0, "R5", "second step alone", int'(unlocked), 0);
    wr(0, 8'h55); idle(3); wr(0, 8'hAA);
    chk(unlocked == 1, "R5", "idle between steps", int'(unlocked), 1);
    idle(20);

    // R6 window boundary: 16th edge accepted, 17th rejected
    wr(0, 8'h55); wr(0, 8'hAA); idle(15); wr(7, 1); idle(1);
    chk(pin_oe[6] == 1, "R6", "write on 16th edge", int'(pin_oe[6]), 1);
    idle(5);
    wr(0, 8'h55); wr(0, 8'hAA); idle(16); wr(8, 1); idle(1);
    chk(pin_oe[7] == 0, "R6", "write on 17th edge", int'(pin_oe[7]), 0);
    idle(5);

    // R8 corrupt shadow of pin 2 and input 1
    for (int r = 0; r < NREG; r++)
      fv[r*SELW +: SELW] = SELW'((r < NPINS) ? psel[r] : isel[r - NPINS]);
    fv[2*SELW] = ~fv[2*SELW];
    fv[(NPINS+1)*SELW] = ~fv[(NPINS+1)*SELW];
    force uut.u_cfg.u_shadow.q = fv;
    pmask[2] = 1; imask[1] = 1;
    idle(2);
    chk(fault == 1, "R8", "fault raised", int'(fault), 1);
    chk(pin_oe[2] == 0, "R8", "faulted pin disabled", int'(pin_oe[2]), 0);
    chk(pin_oe[0] == 1, "R8", "other pin unaffected", int'(pin_oe[0]), 1);
    release uut.u_cfg.u_shadow.q;
    pmask[2] = 0; imask[1] = 0;
    idle(5);
    chk(fault == 1, "R8", "fault sticky", int'(fault), 1);

    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    chk(fault == 0 && pin_oe == 0, "R1", "clean after reset", int'({fault, pin_oe}), 0);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule